// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block gives a host a simple command port for reading and writing the control registers of a PHY. The PHY itself is reached over a narrow handshake bus: one shared input bus (`phy_din`), four one-bit capture and access strobes, an acknowledge input and a read-data bus. Each strobe is a complete four-phase exchange. The master raises the strobe, waits for acknowledge to go high, drops the strobe, and then waits for acknowledge to go low.

Every access starts with an address phase. A read then runs a single read-strobe phase and captures the PHY's output data while acknowledge is high. A write runs a data-capture phase with the write data on the shared bus, followed by a separate write-strobe phase. Acknowledge arrives from another clock domain, so it passes through a two-flop synchronizer first. Every wait for acknowledge is bounded by a cycle-count watchdog. When a wait expires, the access carries on to its end and raises a sticky error flag, which is reported together with `cmd_done`.

Top module: `phy_cr_master`

## Requirements
- R1: While reset is held and right after it, `cmd_busy`, `cmd_done`, `cmd_timeout`, all four strobes and `phy_din` are 0.
- R2: An access begins by placing `cmd_addr` on `phy_din` with every strobe low, then raising `phy_cap_addr`. `phy_din` holds steady for as long as `phy_cap_addr` or `phy_cap_data` is high.
- R3: After raising a strobe, the master drops it only once the synchronized acknowledge is seen high or the wait has expired. It starts the next phase only once acknowledge is seen low or that wait has expired. Acknowledge passes through two flops before the sequencer sees it.
- R4: A read (`cmd_write`=0) raises `phy_cap_addr` and then `phy_rd`, and no other strobe. `cmd_rdata` holds the value of `phy_dout` taken while acknowledge is high during the read phase.
- R5: A write (`cmd_write`=1) raises `phy_cap_addr`, then `phy_cap_data` with `cmd_wdata` on `phy_din`, then `phy_wr`, in that order.
- R6: At most one of the four strobes is high in any cycle.
- R7: A wait for acknowledge, rising or falling, is abandoned after TIMEOUT_CYC cycles. The access then moves on, so an access that gets no acknowledge at all still finishes. For a read, that takes between 2*TIMEOUT_CYC and 2*TIMEOUT_CYC+8 cycles.
- R8: `cmd_timeout` is set by any expired wait and stays set through the `cmd_done` of that access. It is cleared when the next start is accepted.
- R9: A `cmd_start` that arrives while `cmd_busy` is high is ignored. It launches no access on the PHY bus and changes no register in the PHY.
- R10: `cmd_done` is high for exactly one cycle after the final acknowledge-low wait, and `cmd_busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Request an access (taken only when idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | BUS_W | PHY register address |
| cmd_wdata | input | BUS_W | Write data |
| cmd_busy | output | 1 | Access in progress |
| cmd_done | output | 1 | One-cycle end-of-access pulse |
| cmd_rdata | output | BUS_W | Data returned by the last read |
| cmd_timeout | output | 1 | Sticky: an acknowledge wait expired in this access |
| phy_din | output | BUS_W | Shared address/data bus to the PHY |
| phy_cap_addr | output | 1 | Address-capture strobe |
| phy_cap_data | output | 1 | Data-capture strobe |
| phy_rd | output | 1 | Read strobe |
| phy_wr | output | 1 | Write strobe |
| phy_ack | input | 1 | PHY acknowledge (asynchronous) |
| phy_dout | input | BUS_W | PHY read data, valid while acknowledge is high |

## Verification
The assertions check the cycle-level rules on every cycle: strobes are mutually exclusive, `phy_din` holds steady under a capture strobe, no strobe drops without a synchronized acknowledge or an expired wait, the done pulse is single and busy is low with it, and the error flag is clear when an access is accepted. Only the bench scenarios can show the things that need a PHY model. These are the strobe order for reads and writes, which address and data the PHY actually latched, whether read data is taken from the acknowledged window, how long an access takes when the PHY never acknowledges or never releases acknowledge, and that a start arriving mid-access leaves the PHY registers untouched.

// File: rtl/phy_cr_pkg.sv
// Shared types for the PHY control-register handshake master.
// Assumes: the phase encoding doubles as the index of the strobe vector.
package phy_cr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_HI   = 2'd2,
        ST_LO   = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_DATA = 2'd1,
        PH_RD   = 2'd2,
        PH_WR   = 2'd3
    } phase_t;

    localparam int NUM_STROBES = 4;
endpackage

// File: rtl/cr_ack_sync.sv
// Multi-flop synchronizer for the PHY acknowledge.
// Assumes: the input is a level that stays put for several destination cycles.
module cr_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/cr_wait_timer.sv
// Cycle counter that bounds a single acknowledge wait.
// Assumes: 'arm' is high for the whole wait, and 'clr' pulses on the cycle the
// wait ends so that a back-to-back wait starts from zero.
module cr_wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clr,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count the cycles spent in the current wait, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || clr) cnt_q <= '0;
        else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
    end

    assign expired = arm && (cnt_q == LAST);
endmodule

// File: rtl/cr_sequencer.sv
// Phase sequencer: builds a read (address, read) or a write (address, data,
// write) out of four-phase strobe exchanges and reports the result.
// Assumes: ack_s is already synchronized, and dout is valid while ack_s is high.
module cr_sequencer
    import phy_cr_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   op_write,
    input  logic [BUS_W-1:0]       addr,
    input  logic [BUS_W-1:0]       wdata,
    input  logic                   ack_s,
    input  logic [BUS_W-1:0]       dout,
    input  logic                   tmr_expired,
    output logic                   busy,
    output logic                   done,
    output logic [BUS_W-1:0]       rdata,
    output logic                   timeout,
    output logic [BUS_W-1:0]       din,
    output logic [NUM_STROBES-1:0] stb,
    output logic                   wait_arm,
    output logic                   wait_clr
);
    seq_state_t        state_q;
    phase_t            phase_q;
    logic              is_write_q;
    logic [BUS_W-1:0]  wdata_q;
    logic [BUS_W-1:0]  din_q;
    logic [BUS_W-1:0]  rdata_q;
    logic [NUM_STROBES-1:0] stb_q;
    logic              tmo_q;
    logic              done_q;
    logic              hi_exit;
    logic              lo_exit;
    logic              last_phase;

    // Decide when the current acknowledge wait is over.
    always_comb begin
        hi_exit    = (state_q == ST_HI) && (ack_s || tmr_expired);
        lo_exit    = (state_q == ST_LO) && (!ack_s || tmr_expired);
        last_phase = (phase_q == PH_RD) || (phase_q == PH_WR);
    end

    // Main phase state machine with strobe, bus and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            phase_q    <= PH_ADDR;
            is_write_q <= 1'b0;
            wdata_q    <= '0;
            din_q      <= '0;
            rdata_q    <= '0;
            stb_q      <= '0;
            tmo_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        is_write_q <= op_write;
                        wdata_q    <= wdata;
                        din_q      <= addr;
                        phase_q    <= PH_ADDR;
                        tmo_q      <= 1'b0;
                        state_q    <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    stb_q[phase_q] <= 1'b1;
                    state_q        <= ST_HI;
                end
                ST_HI: begin
                    if (hi_exit) begin
                        stb_q <= '0;
                        if (!ack_s) tmo_q <= 1'b1;
                        if (ack_s && phase_q == PH_RD) rdata_q <= dout;
                        state_q <= ST_LO;
                    end
                end
                ST_LO: begin
                    if (lo_exit) begin
                        if (ack_s) tmo_q <= 1'b1;
                        if (last_phase) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_PREP;
                            if (phase_q == PH_DATA) begin
                                phase_q <= PH_WR;
                            end else if (is_write_q) begin
                                phase_q <= PH_DATA;
                                din_q   <= wdata_q;
                            end else begin
                                phase_q <= PH_RD;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign rdata    = rdata_q;
    assign timeout  = tmo_q;
    assign din      = din_q;
    assign stb      = stb_q;
    assign wait_arm = (state_q == ST_HI) || (state_q == ST_LO);
    assign wait_clr = hi_exit || lo_exit;
endmodule

// File: rtl/phy_cr_master.sv
// Top level of the PHY control-register handshake master: synchronizer,
// wait watchdog and phase sequencer.
// Assumes: phy_ack is asynchronous, phy_dout is stable while acknowledge is high.
module phy_cr_master
    import phy_cr_pkg::*;
#(
    parameter int BUS_W       = 16,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [BUS_W-1:0] cmd_addr,
    input  logic [BUS_W-1:0] cmd_wdata,
    output logic             cmd_busy,
    output logic             cmd_done,
    output logic [BUS_W-1:0] cmd_rdata,
    output logic             cmd_timeout,
    output logic [BUS_W-1:0] phy_din,
    output logic             phy_cap_addr,
    output logic             phy_cap_data,
    output logic             phy_rd,
    output logic             phy_wr,
    input  logic             phy_ack,
    input  logic [BUS_W-1:0] phy_dout
);
    logic                   ack_s;
    logic                   wait_expired;
    logic                   wait_arm;
    logic                   wait_clr;
    logic [NUM_STROBES-1:0] stb;

    cr_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (phy_ack),
        .sync_out (ack_s)
    );

    cr_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (wait_arm),
        .clr     (wait_clr),
        .expired (wait_expired)
    );

    cr_sequencer #(.BUS_W(BUS_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cmd_start),
        .op_write    (cmd_write),
        .addr        (cmd_addr),
        .wdata       (cmd_wdata),
        .ack_s       (ack_s),
        .dout        (phy_dout),
        .tmr_expired (wait_expired),
        .busy        (cmd_busy),
        .done        (cmd_done),
        .rdata       (cmd_rdata),
        .timeout     (cmd_timeout),
        .din         (phy_din),
        .stb         (stb),
        .wait_arm    (wait_arm),
        .wait_clr    (wait_clr)
    );

    assign phy_cap_addr = stb[PH_ADDR];
    assign phy_cap_data = stb[PH_DATA];
    assign phy_rd       = stb[PH_RD];
    assign phy_wr       = stb[PH_WR];
endmodule

// File: rtl/phy_cr_master_chk.sv
// Protocol checker for phy_cr_master, attached by bind.
// Assumes: the watchdog expiry flag of the top is brought out as wait_expired.
module phy_cr_master_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_busy,
    input logic             cmd_done,
    input logic             cmd_timeout,
    input logic [BUS_W-1:0] phy_din,
    input logic             phy_cap_addr,
    input logic             phy_cap_data,
    input logic             phy_rd,
    input logic             phy_wr,
    input logic             phy_ack,
    input logic             wait_expired
);
    logic any_stb;
    logic cap_stb;
    assign any_stb = phy_cap_addr | phy_cap_data | phy_rd | phy_wr;
    assign cap_stb = phy_cap_addr | phy_cap_data;

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phy_cap_addr, phy_cap_data, phy_rd, phy_wr}));

    // R2
    din_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb && $past(cap_stb)) |-> $stable(phy_din));

    // R3
    drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_stb) |-> ($past(phy_ack, 3) || $past(wait_expired)));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !cmd_busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |-> !cmd_timeout);
endmodule

bind phy_cr_master phy_cr_master_chk #(.BUS_W(BUS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_busy     (cmd_busy),
    .cmd_done     (cmd_done),
    .cmd_timeout  (cmd_timeout),
    .phy_din      (phy_din),
    .phy_cap_addr (phy_cap_addr),
    .phy_cap_data (phy_cap_data),
    .phy_rd       (phy_rd),
    .phy_wr       (phy_wr),
    .phy_ack      (phy_ack),
    .wait_expired (wait_expired)
);

// File: tb/phy_cr_master_tb.sv
module phy_cr_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BW         = 16;
    localparam int TMO        = 32;
    localparam int WAIT_LIM   = 2000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic          cmd_write = 1'b0;
    logic [BW-1:0] cmd_addr = '0;
    logic [BW-1:0] cmd_wdata = '0;
    logic          cmd_busy, cmd_done, cmd_timeout;
    logic [BW-1:0] cmd_rdata, phy_din, phy_dout;
    logic          phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
    logic          phy_ack;

    int checks = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_cr_master #(.BUS_W(BW), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done),
        .cmd_rdata(cmd_rdata), .cmd_timeout(cmd_timeout),
        .phy_din(phy_din), .phy_cap_addr(phy_cap_addr),
        .phy_cap_data(phy_cap_data), .phy_rd(phy_rd), .phy_wr(phy_wr),
        .phy_ack(phy_ack), .phy_dout(phy_dout)
    );

    // ---------------- PHY model: 0 normal, 1 silent, 2 ack stuck high
    int            phy_mode = 0;
    int            phy_dly = 0;
    int            dcnt;
    logic [BW-1:0] mem [16];
    logic [BW-1:0] cur_addr, cur_data, rd_val, din_prev;
    logic [3:0]    stb_prev;
    logic [11:0]   seq;
    int            evt_cnt, multi_hot, early_drop, stab_err;
    logic [3:0]    stb_now;

    assign stb_now  = {phy_wr, phy_rd, phy_cap_data, phy_cap_addr};
    assign phy_dout = phy_ack ? rd_val : 16'hBAD0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            phy_ack <= 1'b0; dcnt <= 0; stb_prev <= '0; din_prev <= '0;
            cur_addr <= '0; cur_data <= '0; rd_val <= '0; seq <= '0;
            evt_cnt <= 0; multi_hot <= 0; early_drop <= 0; stab_err <= 0;
        end else begin
            stb_prev <= stb_now;
            din_prev <= phy_din;
            if ($countones(stb_now) > 1) multi_hot <= multi_hot + 1;
            if ((stb_now[1:0] & stb_prev[1:0]) != 2'b00 && phy_din != din_prev)
                stab_err <= stab_err + 1;
            if (phy_mode == 0 && (stb_prev & ~stb_now) != 4'b0 && !phy_ack)
                early_drop <= early_drop + 1;
            if (stb_now == 4'b0) begin
                dcnt <= 0;
                if (phy_mode != 2) phy_ack <= 1'b0;
            end else if (phy_mode != 1) begin
                if (dcnt >= phy_dly) phy_ack <= 1'b1;
                else dcnt <= dcnt + 1;
            end
            if (stb_now[0] && !stb_prev[0]) begin
                cur_addr <= phy_din; seq <= {seq[7:0], 4'h1}; evt_cnt <= evt_cnt + 1;
            end
            if (stb_now[1] && !stb_prev[1]) begin
                cur_data <= phy_din; seq <= {seq[7:0], 4'h2}; evt_cnt <= evt_cnt + 1;
            end
            if (stb_now[2] && !stb_prev[2]) begin
                rd_val <= mem[cur_addr[3:0]]; seq <= {seq[7:0], 4'h3}; evt_cnt <= evt_cnt + 1;
            end
            if (stb_now[3] && !stb_prev[3]) begin
                mem[cur_addr[3:0]] <= cur_data; seq <= {seq[7:0], 4'h4}; evt_cnt <= evt_cnt + 1;
            end
        end
    end

    // ---------------- check helpers
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // Issue one access and wait for done; R10 checked on every access.
    task automatic run_access(input logic wr, input logic [BW-1:0] a, input logic [BW-1:0] d,
                              output logic [BW-1:0] rd, output logic tmo, output int cyc);
        @(negedge clk);
        cmd_start = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_start = 1'b0;
        cyc = 1;
        while (!cmd_done && cyc < WAIT_LIM) begin
            @(negedge clk);
            cyc++;
        end
        rd = cmd_rdata; tmo = cmd_timeout;
        chk("R10 done seen", 32'(cmd_done), 32'd1);
        chk("R10 busy low with done", 32'(cmd_busy), 32'd0);
        @(negedge clk);
        chk("R10 done one cycle", 32'(cmd_done), 32'd0);
    endtask

    // ---------------- scenarios
    task automatic test_reset();
        chk("R1 busy", 32'(cmd_busy), 32'd0);
        chk("R1 done", 32'(cmd_done), 32'd0);
        chk("R1 timeout", 32'(cmd_timeout), 32'd0);
        chk("R1 strobes", 32'(stb_now), 32'd0);
        chk("R1 din", 32'(phy_din), 32'd0);
    endtask

    task automatic test_write_read(input int dly, input logic [BW-1:0] a, input logic [BW-1:0] d);
        logic [BW-1:0] rd; logic tmo; int cyc; int e0;
        phy_mode = 0; phy_dly = dly;
        e0 = evt_cnt;
        run_access(1'b1, a, d, rd, tmo, cyc);
        chk("R5 write event count", 32'(evt_cnt - e0), 32'd3);
        chk("R5 write order A,D,W", 32'(seq), 32'h124);
        chk("R2 address captured", 32'(cur_addr), 32'(a));
        chk("R5 data captured", 32'(cur_data), 32'(d));
        chk("R7 no timeout", 32'(tmo), 32'd0);
        e0 = evt_cnt;
        run_access(1'b0, a, '0, rd, tmo, cyc);
        chk("R4 read event count", 32'(evt_cnt - e0), 32'd2);
        chk("R4 read order A,R", 32'(seq[7:0]), 32'h13);
        chk("R4 read data", 32'(rd), 32'(d));
        chk("R8 flag clear", 32'(tmo), 32'd0);
    endtask

    task automatic test_no_ack();
        logic [BW-1:0] rd; logic tmo; int cyc;
        phy_mode = 1;
        run_access(1'b0, 16'h0003, '0, rd, tmo, cyc);
        chk("R7 silent PHY timeout", 32'(tmo), 32'd1);
        chk_range("R7 silent PHY duration", cyc, 2*TMO, 2*TMO+8);
        phy_mode = 0;
        run_access(1'b0, 16'h0003, '0, rd, tmo, cyc);
        chk("R8 flag cleared by next access", 32'(tmo), 32'd0);
    endtask

    task automatic test_stuck_ack();
        logic [BW-1:0] rd; logic tmo; int cyc;
        phy_mode = 2; phy_dly = 1;
        run_access(1'b1, 16'h0007, 16'h5A5A, rd, tmo, cyc);
        chk("R7 stuck ack timeout", 32'(tmo), 32'd1);
        chk_range("R7 stuck ack finishes", cyc, 1, 4*TMO+16);
        phy_mode = 0;
        repeat (3) @(negedge clk);
        chk("R8 flag held after done", 32'(cmd_timeout), 32'd1);
    endtask

    task automatic test_busy_ignore();
        logic [BW-1:0] rd; int cyc; int e0; logic tmo;
        phy_mode = 0; phy_dly = 2;
        e0 = evt_cnt;
        @(negedge clk);
        cmd_start = 1'b1; cmd_write = 1'b0; cmd_addr = 16'h0009; cmd_wdata = '0;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (4) @(negedge clk);
        cmd_start = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0005; cmd_wdata = 16'hAAAA;
        @(negedge clk);
        cmd_start = 1'b0;
        cyc = 0;
        while (!cmd_done && cyc < WAIT_LIM) begin @(negedge clk); cyc++; end
        rd = cmd_rdata;
        repeat (40) @(negedge clk);
        chk("R9 only one access", 32'(evt_cnt - e0), 32'd2);
        chk("R9 first read data", 32'(rd), 32'h9009);
        run_access(1'b0, 16'h0005, '0, rd, tmo, cyc);
        chk("R9 register untouched", 32'(rd), 32'h5005);
    endtask

    // ---------------- monitors summary
    task automatic test_monitors();
        chk("R6 multiple strobes", 32'(multi_hot), 32'd0);
        chk("R2 din changed under capture", 32'(stab_err), 32'd0);
        chk("R3 strobe dropped before ack", 32'(early_drop), 32'd0);
    endtask

    // ---------------- watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_write_read(0, 16'h0005, 16'h5005);
        test_write_read(5, 16'h0009, 16'h9009);
        test_write_read(1, 16'h0003, 16'hC3C3);
        test_no_ack();
        test_stuck_ack();
        test_busy_ignore();
        test_monitors();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule